// File: doc/BRIEF.md
# Status Poll Match Unit

This unit watches the stream of status words that an external device returns while it is being polled. Each accepted word is compared, bit by bit under a mask, with a programmed reference value. One of two rules decides whether it is a hit. With the all-bits rule, every enabled bit must agree. With the any-bit rule, a single agreeing enabled bit is enough. A sticky flag records a hit, and an interrupt output passes that flag on when it is enabled.

A poll session starts with a start pulse. It then runs until it is ended. When the stop-on-hit option is set, the first hit ends the session. When that option is clear, the session keeps running through hits until an abort or a drop of the enable input. After every accepted word that does not end the session, the unit pulses a request for the next poll read. A one-cycle done pulse marks the end of every session. Issuing the read commands and timing the gaps between polls are handled outside this unit.

Status words arrive on a valid/ready stream. Ready is high only while a session is running, enable is high and no abort is requested. A word is consumed on a clock edge where both valid and ready are high. The sender must hold the word and valid until that edge. The rule and stop-on-hit inputs are sampled only while no session is running, and they are frozen for the length of a session.

Top module: `stpoll_matcher`

## Requirements
- R1: Under the all-bits rule (`or_mode`=0), an accepted word is a hit when `((stat_data ^ match_val) & mask) == 0`.
- R2: Under the any-bit rule (`or_mode`=1), an accepted word is a hit when `(~(stat_data ^ match_val) & mask) != 0`.
- R3: Bits whose `mask` bit is 0 take no part in the comparison. With an all-zero mask, every word is a hit under the all-bits rule and no word is a hit under the any-bit rule.
- R4: When `auto_stop`=1, a hit ends the session. On the next cycle `busy` is 0, `done` is 1 and `poll_next` is 0.
- R5: `match_flag` rises on the cycle after a hit is accepted. It stays set through any later non-hit words and is cleared only by the next session start.
- R6: When `auto_stop`=0, a hit does not end the session. `busy` stays 1 and `poll_next` pulses on the next cycle. The session ends, with a one-cycle `done` pulse, only when `abort_req` is 1 or `en` is 0.
- R7: The `or_mode` and `auto_stop` inputs are taken only while `busy` is 0. Changing them during a session has no effect on that session.
- R8: `stat_ready` is 1 exactly when `busy`=1, `en`=1 and `abort_req`=0. A word presented while ready is 0 is not consumed.
- R9: `irq` is 1 only when both `irq_en` and `match_flag` are 1.
- R10: After reset, `busy`, `match_flag`, `done`, `poll_next` and `irq` are 0. A `start` pulse while `en` is 0 leaves `busy` at 0.
- R11: `abort_req` needs no clearing. An abort applied while idle has no effect on the next session.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Unit enable; dropping it ends a session |
| start | input | 1 | Pulse that opens a poll session when idle and enabled |
| abort_req | input | 1 | Ends the running session; needs no clearing |
| or_mode | input | 1 | 0 all-bits rule, 1 any-bit rule |
| auto_stop | input | 1 | 1 ends the session on the first hit |
| irq_en | input | 1 | Interrupt enable for the match flag |
| mask | input | W | 1 marks a bit that takes part in the comparison |
| match_val | input | W | Reference value |
| stat_valid | input | 1 | Status word valid |
| stat_ready | output | 1 | Status word can be consumed |
| stat_data | input | W | Status word from the device |
| match_flag | output | 1 | Sticky hit flag |
| poll_next | output | 1 | Pulse asking for the next poll read |
| done | output | 1 | One-cycle pulse when a session ends |
| busy | output | 1 | Session running |
| irq | output | 1 | Match interrupt |

## Verification
Two events can fall in the same cycle: a hit word on the stream and an abort request. The bench provokes this by raising `abort_req` together with a valid word that would be a hit. It then checks that ready was 0 in that cycle, and that on the next cycle the session has ended with `done` high and `match_flag` still 0. A second collision is a rule change during a running session. Here the bench sends a word that hits only under the newly requested rule, and checks that the flag stays 0. Around these cases, a sweep over every rule, mask, reference and word of a 4-bit build checks the flag, `busy`, `done` and `poll_next` against the R1/R2 formulas.

// File: rtl/stpoll_pkg.sv
package stpoll_pkg;

  typedef enum logic {
    RULE_ALL = 1'b0,
    RULE_ANY = 1'b1
  } match_rule_e;

  typedef struct packed {
    match_rule_e rule;
    logic        auto_stop;
  } poll_cfg_t;

endpackage

// File: rtl/stpoll_compare.sv
module stpoll_compare
  import stpoll_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] word,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] ref_val,
  input  match_rule_e  rule,
  output logic         hit
);

  logic [W-1:0] agree;
  logic [W-1:0] bad;

  // One comparator cell per bit position
  for (genvar b = 0; b < W; b++) begin : g_bit
    assign agree[b] = mask[b] & ~(word[b] ^ ref_val[b]);
    assign bad[b]   = mask[b] &  (word[b] ^ ref_val[b]);
  end

  always_comb begin
    if (rule == RULE_ALL) hit = ~|bad;
    else                  hit = |agree;
  end

  // R3: an empty mask makes the result depend on the rule alone
  always_comb begin
    if (mask == '0) begin
      p_empty_mask_r3: assert (hit == (rule == RULE_ALL))
        else $error("empty-mask result wrong");
    end
  end

endmodule

// File: rtl/stpoll_cfg.sv
module stpoll_cfg
  import stpoll_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      busy,
  input  logic      or_mode,
  input  logic      auto_stop,
  output poll_cfg_t cfg
);

  // Configuration follows its inputs while idle and holds during a session
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '{rule: RULE_ALL, auto_stop: 1'b0};
    end else if (!busy) begin
      cfg.rule      <= or_mode ? RULE_ANY : RULE_ALL;
      cfg.auto_stop <= auto_stop;
    end
  end

  p_cfg_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cfg))
    else $error("configuration changed during a session");

endmodule

// File: rtl/stpoll_ctrl.sv
module stpoll_ctrl
  import stpoll_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en,
  input  logic      start,
  input  logic      abort_req,
  input  poll_cfg_t cfg,
  input  logic      stat_valid,
  input  logic      hit,
  output logic      stat_ready,
  output logic      busy,
  output logic      match_flag,
  output logic      poll_next,
  output logic      done
);

  logic start_fire;
  logic take;
  logic stop_req;

  assign start_fire = start && en && !busy;
  assign stop_req   = !en || abort_req;
  assign stat_ready = busy && !stop_req;
  assign take       = stat_valid && stat_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      match_flag <= 1'b0;
      poll_next  <= 1'b0;
      done       <= 1'b0;
    end else begin
      poll_next <= 1'b0;
      done      <= 1'b0;
      if (start_fire) begin
        busy       <= 1'b1;
        match_flag <= 1'b0;
      end else if (busy) begin
        if (stop_req) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else if (take) begin
          if (hit) match_flag <= 1'b1;
          if (hit && cfg.auto_stop) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            poll_next <= 1'b1;
          end
        end
      end
    end
  end

  p_autostop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && hit && cfg.auto_stop) |=> (!busy && done && !poll_next))
    else $error("auto-stop did not end the session");

  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (match_flag && !start_fire) |=> match_flag)
    else $error("match flag dropped");

  p_hit_sets_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && hit) |=> match_flag)
    else $error("hit not recorded");

  p_stop_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && stop_req && !start_fire) |=> (!busy && done))
    else $error("abort or disable did not end the session");

  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy)
    else $error("done while busy");

  p_ready_only_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stat_ready |-> (busy && en))
    else $error("ready outside a session");

endmodule

// File: rtl/stpoll_matcher.sv
module stpoll_matcher
  import stpoll_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         start,
  input  logic         abort_req,
  input  logic         or_mode,
  input  logic         auto_stop,
  input  logic         irq_en,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] match_val,
  input  logic         stat_valid,
  output logic         stat_ready,
  input  logic [W-1:0] stat_data,
  output logic         match_flag,
  output logic         poll_next,
  output logic         done,
  output logic         busy,
  output logic         irq
);

  poll_cfg_t cfg;
  logic      hit;

  stpoll_cfg u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .or_mode   (or_mode),
    .auto_stop (auto_stop),
    .cfg       (cfg)
  );

  stpoll_compare #(.W(W)) u_cmp (
    .word    (stat_data),
    .mask    (mask),
    .ref_val (match_val),
    .rule    (cfg.rule),
    .hit     (hit)
  );

  stpoll_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .start      (start),
    .abort_req  (abort_req),
    .cfg        (cfg),
    .stat_valid (stat_valid),
    .hit        (hit),
    .stat_ready (stat_ready),
    .busy       (busy),
    .match_flag (match_flag),
    .poll_next  (poll_next),
    .done       (done)
  );

  assign irq = irq_en & match_flag;

  p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> irq_en)
    else $error("interrupt without enable");

endmodule

// File: tb/stpoll_matcher_test.sv
module stpoll_matcher_test;

  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         en = 1'b0, start = 1'b0, abort_req = 1'b0;
  logic         or_mode = 1'b0, auto_stop = 1'b0, irq_en = 1'b0;
  logic [W-1:0] mask = '0, match_val = '0, stat_data = '0;
  logic         stat_valid = 1'b0;
  logic         stat_ready, match_flag, poll_next, done, busy, irq;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  stpoll_matcher #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .start(start), .abort_req(abort_req),
    .or_mode(or_mode), .auto_stop(auto_stop), .irq_en(irq_en), .mask(mask),
    .match_val(match_val), .stat_valid(stat_valid), .stat_ready(stat_ready),
    .stat_data(stat_data), .match_flag(match_flag), .poll_next(poll_next),
    .done(done), .busy(busy), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      summary();
    end
  end

  function automatic bit model_hit(bit any, logic [W-1:0] m, logic [W-1:0] r, logic [W-1:0] d);
    if (!any) return ((d ^ r) & m) == 0;
    return (~(d ^ r) & m) != 0;
  endfunction

  task automatic open_session();
    start = 1'b1;
    step();
    start = 1'b0;
  endtask

  task automatic close_by_abort();
    if (busy) begin
      abort_req = 1'b1;
      step();
      abort_req = 1'b0;
    end
  endtask

  initial begin
    en = 1'b1;
    step(); step();
    // R10: reset state
    chk("R10 busy", busy, 0);
    chk("R10 flag", match_flag, 0);
    chk("R10 done", done, 0);
    chk("R10 poll_next", poll_next, 0);
    chk("R10 irq", irq, 0);
    rst_n = 1'b1;
    step();

    // R10: start while disabled is ignored
    en = 1'b0;
    open_session();
    chk("R10 start while disabled", busy, 0);
    en = 1'b1;
    // R8: no ready while idle
    stat_valid = 1'b1;
    chk("R8 ready idle", stat_ready, 0);
    stat_valid = 1'b0;

    // R1 R2 R3 R4 R5: sweep with auto-stop
    auto_stop = 1'b1;
    for (int rl = 0; rl < 2; rl++) begin
      for (int m = 0; m < 16; m++) begin
        for (int r = 0; r < 16; r++) begin
          for (int d = 0; d < 16; d++) begin
            bit e;
            or_mode = rl[0];
            mask = m[W-1:0];
            match_val = r[W-1:0];
            e = model_hit(rl[0], m[W-1:0], r[W-1:0], d[W-1:0]);
            open_session();
            stat_data = d[W-1:0];
            stat_valid = 1'b1;
            step();
            stat_valid = 1'b0;
            chk(rl[0] ? "R2 sweep" : "R1 sweep",
                {m[7:0], r[7:0], d[7:0], 3'b0, match_flag, busy, done, poll_next, 1'b0},
                {m[7:0], r[7:0], d[7:0], 3'b0, e, !e, e, !e, 1'b0});
            close_by_abort();
          end
        end
      end
    end

    // R6 R5: no auto-stop, runs through hits
    auto_stop = 1'b0; or_mode = 1'b0; mask = 4'hF; match_val = 4'h5;
    step();
    open_session();
    stat_data = 4'h5; stat_valid = 1'b1;
    step();
    stat_valid = 1'b0;
    chk("R6 busy after hit", busy, 1);
    chk("R6 poll_next after hit", poll_next, 1);
    chk("R5 flag after hit", match_flag, 1);
    // R9: irq gating
    chk("R9 irq disabled", irq, 0);
    irq_en = 1'b1;
    #0;
    chk("R9 irq enabled", irq, 1);
    stat_data = 4'h0; stat_valid = 1'b1;
    step();
    stat_valid = 1'b0;
    chk("R5 flag sticky", match_flag, 1);
    en = 1'b0;
    step();
    chk("R6 disable ends", {busy, done}, 2'b01);
    en = 1'b1;
    step();
    chk("R6 done one cycle", done, 0);
    chk("R5 flag kept idle", match_flag, 1);
    irq_en = 1'b0;

    // R7: rule change during session ignored
    or_mode = 1'b0; auto_stop = 1'b1; mask = 4'hF; match_val = 4'h0;
    step();
    open_session();
    chk("R5 start clears flag", match_flag, 0);
    or_mode = 1'b1;
    stat_data = 4'h1; stat_valid = 1'b1;
    step();
    stat_valid = 1'b0;
    chk("R7 frozen rule", {match_flag, busy}, 2'b01);
    close_by_abort();

    // R8 R6: abort collides with a hitting word
    or_mode = 1'b0; mask = 4'h3; match_val = 4'h2;
    step();
    open_session();
    stat_data = 4'h2; stat_valid = 1'b1; abort_req = 1'b1;
    #0;
    chk("R8 ready low on abort", stat_ready, 0);
    step();
    stat_valid = 1'b0; abort_req = 1'b0;
    chk("R6 abort wins", {match_flag, busy, done}, 3'b001);

    // R11: abort while idle has no lasting effect
    abort_req = 1'b1;
    step();
    abort_req = 1'b0;
    open_session();
    chk("R11 session after idle abort", busy, 1);
    stat_data = 4'h6; stat_valid = 1'b1;
    step();
    stat_valid = 1'b0;
    chk("R11 hit after idle abort", {match_flag, busy, done}, 3'b101);

    summary();
  end

endmodule